// File: doc/BRIEF.md
# Debug Test Access Port with Halt Enable Key

This block is the target-side test access port of a processor debug path. It runs entirely on the test clock, so it keeps working while the core clock is stopped. It holds the usual sixteen-state controller, a 4-bit instruction register and a one-bit bypass path. It also has a debug chain that carries a halt request towards the core and reports back whether the core has halted.

A private 2-bit key register sits between the scan path and the core. A halt request written through the debug chain is dropped until the key register has been loaded with the enabling pattern. After that, halt and resume requests pass through any number of times. The enable stays set until the asynchronous reset input is asserted. Controller resets through TMS leave it set. A request that has been latched stays on the output until it is cleared. The core takes the request on its next clock and reports the halt on its status input.

Top module: `dbg_tap_unlock`

## Requirements
- R1: While `trst_n` is low, `dbg_req` and `tdo` are 0, the key is disarmed, the latched request is cleared, and the instruction register holds the bypass opcode 4'b1111. After release, the controller is in Test-Logic-Reset.
- R2: The controller follows the standard sixteen-state TMS graph, sampling TMS on the rising edge of `tck`. Five clocks with TMS=1 reach Test-Logic-Reset from any state, and that state reloads the bypass opcode.
- R3: The instruction register is 4 bits wide. Capture-IR loads 4'b0001. Shift-IR presents bit 0 on `tdo` first, and `tdi` enters at bit 3. The new opcode takes effect on Update-IR.
- R4: Opcode 4'b1111, and every opcode other than 4'b0010 and 4'b1011, selects a one-bit bypass register. That register captures 0 and delays `tdi` by one shift.
- R5: Opcode 4'b1011 selects the 2-bit key register. Capture-DR loads it with bit 0 = the armed flag and bit 1 = 0. Shifting is LSB first, with `tdi` entering at bit 1.
- R6: On Update-DR with opcode 4'b1011, the armed flag is set only if the key register holds 2'b10. Any other value leaves the flag unchanged.
- R7: Opcode 4'b0010 selects the 2-bit debug chain. Capture-DR loads bit 0 with the latched request and bit 1 with `core_halted`. Shifting is LSB first, with `tdi` entering at bit 1.
- R8: On Update-DR of the debug chain, the latched request takes bit 0, but only while armed. While disarmed, the request stays 0, so `dbg_req` stays 0.
- R9: Once armed, the request can be set and cleared any number of times with no further key load. The armed flag and the latched request survive Test-Logic-Reset, and only `trst_n` clears them.
- R10: `tdo` carries the selected register's bit 0 in Shift-IR and Shift-DR, and is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset of the whole port |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| core_halted | input | 1 | Core reports that it is halted in debug |
| tdo | output | 1 | Serial data out, combinational from state |
| dbg_req | output | 1 | Halt request to the core, gated by the key |

## Verification
The assertions assume the following about the inputs:
- `trst_n` is released away from a rising edge of `tck`.
- `tms` and `tdi` are stable around that edge.
- `core_halted` may change at any time, but it is only sampled in Capture-DR.

The stimulus changes every input on the falling edge of `tck` and releases reset on a falling edge. Results are read two time units after the falling edge, which is well clear of the rising edge at which the next state and shift values appear.

// File: rtl/dbg_tap_unlock.sv
`timescale 1ns/1ps
module dbg_tap_unlock #(
  parameter int IR_W = 4,
  parameter int KEY_W = 2,
  parameter logic [IR_W-1:0] OP_DBG = 4'b0010,
  parameter logic [IR_W-1:0] OP_KEY = 4'b1011,
  parameter logic [KEY_W-1:0] KEY_VAL = 2'b10
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic core_halted,
  output logic tdo,
  output logic dbg_req
);
  localparam logic [IR_W-1:0] OP_BYP = '1;
  localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);

  typedef enum logic [3:0] {
    TLR = 4'd0, RTI = 4'd1, SEL_DR = 4'd2, CAP_DR = 4'd3,
    SH_DR = 4'd4, EX1_DR = 4'd5, PAU_DR = 4'd6, EX2_DR = 4'd7,
    UPD_DR = 4'd8, SEL_IR = 4'd9, CAP_IR = 4'd10, SH_IR = 4'd11,
    EX1_IR = 4'd12, PAU_IR = 4'd13, EX2_IR = 4'd14, UPD_IR = 4'd15
  } tap_st_e;

  tap_st_e state, nstate;
  logic [IR_W-1:0] ir, ir_sr;
  logic [KEY_W-1:0] key_sr;
  logic [1:0] dbg_sr;
  logic byp, armed, req_q;

  wire sel_key = (ir == OP_KEY);
  wire sel_dbg = (ir == OP_DBG);

  always_comb begin
    unique case (state)
      TLR:    nstate = tms ? TLR    : RTI;
      RTI:    nstate = tms ? SEL_DR : RTI;
      SEL_DR: nstate = tms ? SEL_IR : CAP_DR;
      CAP_DR: nstate = tms ? EX1_DR : SH_DR;
      SH_DR:  nstate = tms ? EX1_DR : SH_DR;
      EX1_DR: nstate = tms ? UPD_DR : PAU_DR;
      PAU_DR: nstate = tms ? EX2_DR : PAU_DR;
      EX2_DR: nstate = tms ? UPD_DR : SH_DR;
      UPD_DR: nstate = tms ? SEL_DR : RTI;
      SEL_IR: nstate = tms ? TLR    : CAP_IR;
      CAP_IR: nstate = tms ? EX1_IR : SH_IR;
      SH_IR:  nstate = tms ? EX1_IR : SH_IR;
      EX1_IR: nstate = tms ? UPD_IR : PAU_IR;
      PAU_IR: nstate = tms ? EX2_IR : PAU_IR;
      EX2_IR: nstate = tms ? UPD_IR : SH_IR;
      UPD_IR: nstate = tms ? SEL_DR : RTI;
      default: nstate = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state  <= TLR;
      ir     <= OP_BYP;
      ir_sr  <= '0;
      key_sr <= '0;
      dbg_sr <= '0;
      byp    <= 1'b0;
      armed  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      state <= nstate;
      case (state)
        TLR:    ir <= OP_BYP;
        CAP_IR: ir_sr <= IR_CAP;
        SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        UPD_IR: ir <= ir_sr;
        CAP_DR: begin
          byp    <= 1'b0;
          key_sr <= KEY_W'(armed);
          dbg_sr <= {core_halted, req_q};
        end
        SH_DR: begin
          byp <= tdi;
          if (sel_key) key_sr <= {tdi, key_sr[KEY_W-1:1]};
          if (sel_dbg) dbg_sr <= {tdi, dbg_sr[1]};
        end
        UPD_DR: begin
          if (sel_key && key_sr == KEY_VAL) armed <= 1'b1;
          if (sel_dbg && armed) req_q <= dbg_sr[0];
        end
        default: ;
      endcase
    end
  end

  assign tdo = (state == SH_IR) ? ir_sr[0] :
               (state != SH_DR) ? 1'b0 :
               sel_key ? key_sr[0] :
               sel_dbg ? dbg_sr[0] : byp;

  assign dbg_req = armed & req_q;
endmodule

// File: rtl/dbg_tap_unlock_chk.sv
`timescale 1ns/1ps
module dbg_tap_unlock_chk (
  input logic       tck,
  input logic       trst_n,
  input logic [3:0] st,
  input logic [3:0] ir,
  input logic [1:0] key_sr,
  input logic       armed,
  input logic       dbg_req,
  input logic       tdo
);
  localparam logic [3:0] S_TLR = 4'd0;
  localparam logic [3:0] S_SH_DR = 4'd4;
  localparam logic [3:0] S_UPD_DR = 4'd8;
  localparam logic [3:0] S_SH_IR = 4'd11;

  // R8
  no_req_unarmed_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !armed |-> !dbg_req);

  // R9
  armed_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    armed |=> armed);

  // R6
  arm_cause_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(armed) |-> ($past(st) == S_UPD_DR && $past(ir) == 4'b1011 && $past(key_sr) == 2'b10));

  // R2
  tlr_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_TLR) |=> (ir == 4'b1111));

  // R10
  tdo_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st != S_SH_DR && st != S_SH_IR) |-> !tdo);
endmodule

bind dbg_tap_unlock dbg_tap_unlock_chk u_chk (
  .tck(tck), .trst_n(trst_n), .st(state), .ir(ir), .key_sr(key_sr),
  .armed(armed), .dbg_req(dbg_req), .tdo(tdo)
);

// File: tb/test_dbg_tap_unlock.sv
`timescale 1ns/1ps
module test_dbg_tap_unlock;
  localparam int PERIOD = 100;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, core_halted = 1'b0;
  logic tdo, dbg_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic exp_q[$];
  string tag_q[$];

  dbg_tap_unlock i_dbg_tap_unlock (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .core_halted(core_halted), .tdo(tdo), .dbg_req(dbg_req)
  );

  initial forever #(PERIOD/2) tck = ~tck;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  always begin
    @(negedge tck);
    #2;
    if (exp_q.size() > 0) begin
      logic b;
      string t;
      b = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(tdo, b, t);
    end
  end

  task automatic clk_bit(input logic m, input logic d, input logic use_exp,
                         input logic e, input string tag);
    @(negedge tck);
    tms = m;
    tdi = d;
    if (use_exp) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  task automatic scan_ir(input logic [3:0] v, input string tag);
    logic [3:0] cap = 4'b0001;
    clk_bit(1, 0, 0, 0, "");
    clk_bit(1, 0, 0, 0, "");
    clk_bit(0, 0, 0, 0, "");
    clk_bit(0, 0, 0, 0, "");
    for (int i = 0; i < 4; i++) clk_bit(i == 3, v[i], 1, cap[i], tag);
    clk_bit(1, 0, 0, 0, "");
    clk_bit(0, 0, 0, 0, "");
  endtask

  task automatic scan_dr(input int n, input logic [7:0] v, input logic [7:0] e, input string tag);
    clk_bit(1, 0, 0, 0, "");
    clk_bit(0, 0, 0, 0, "");
    clk_bit(0, 0, 0, 0, "");
    for (int i = 0; i < n; i++) clk_bit(i == n - 1, v[i], 1, e[i], tag);
    clk_bit(1, 0, 0, 0, "");
    clk_bit(0, 0, 0, 0, "");
  endtask

  task automatic chk_req(input logic e, input string tag);
    @(negedge tck);
    #2;
    chk(dbg_req, e, tag);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    #2;
    chk(dbg_req, 1'b0, "R1 dbg_req in reset");
    chk(tdo, 1'b0, "R1 tdo in reset");
    @(negedge tck);
    trst_n = 1'b1;
    clk_bit(0, 0, 0, 0, "");
    chk_req(1'b0, "R10 idle");
    chk(tdo, 1'b0, "R10 tdo idle");

    scan_dr(4, 8'h06, 8'h0C, "R4 bypass after reset");
    scan_ir(4'b0010, "R3 ir capture");
    scan_dr(2, 8'h01, 8'h00, "R8 disarmed set");
    chk_req(1'b0, "R8 no request while disarmed");
    scan_dr(2, 8'h00, 8'h00, "R8 request not latched");

    scan_ir(4'b1011, "R3 ir capture key");
    scan_dr(2, 8'h03, 8'h00, "R6 key 11");
    scan_dr(2, 8'h01, 8'h00, "R6 key 01 ignored");
    scan_dr(2, 8'h02, 8'h00, "R5 key 10");
    scan_dr(2, 8'h00, 8'h01, "R6 armed shown");
    scan_dr(2, 8'h00, 8'h01, "R6 key 00 keeps armed");

    scan_ir(4'b0010, "R3 ir to debug");
    scan_dr(2, 8'h01, 8'h00, "R7 capture idle");
    chk_req(1'b1, "R8 request after arming");
    @(negedge tck);
    core_halted = 1'b1;
    scan_dr(2, 8'h00, 8'h03, "R7 capture halted+req");
    chk_req(1'b0, "R9 resume");
    scan_dr(2, 8'h01, 8'h02, "R7 capture halted");
    chk_req(1'b1, "R9 second halt");

    for (int i = 0; i < 5; i++) clk_bit(1, 0, 0, 0, "");
    clk_bit(0, 0, 0, 0, "");
    chk_req(1'b1, "R9 request kept over TLR");
    scan_dr(3, 8'h05, 8'h02, "R2 bypass after TLR");
    scan_ir(4'b1011, "R3 ir key again");
    scan_dr(2, 8'h00, 8'h01, "R9 armed kept over TLR");

    scan_ir(4'b0101, "R3 undefined opcode");
    scan_dr(2, 8'h03, 8'h02, "R4 undefined is bypass");

    @(negedge tck);
    trst_n = 1'b0;
    tms = 1'b1;
    #2;
    chk(dbg_req, 1'b0, "R1 request cleared by reset");
    @(negedge tck);
    trst_n = 1'b1;
    clk_bit(0, 0, 0, 0, "");
    scan_ir(4'b1011, "R3 ir after reset");
    scan_dr(2, 8'h00, 8'h00, "R1 disarmed after reset");
    scan_ir(4'b0010, "R3 ir debug after reset");
    scan_dr(2, 8'h01, 8'h02, "R1 latch cleared");
    chk_req(1'b0, "R8 disarmed again");

    repeat (3) @(negedge tck);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule